// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block performs single-byte reads from an external asynchronous 256K x 8 read-only memory. On a host request it drives the 18-bit address and pulls the active-low chip select, holds the access for as many clock cycles as the memory's slowest access path needs, samples the byte, and hands it to the host with a one-cycle valid strobe. It then raises both enables and keeps the memory deselected for the output-float recovery time before another access may start.

The memory comes in two speed grades, chosen by a parameter. The clock period in nanoseconds is also a parameter. Every wait is derived at elaboration time from the grade's timing and the clock period. The output enable is held back inside the slack the memory allows, so that it falls as late as possible without lengthening the access. A request that arrives while an access or recovery is in progress is held in a single slot and served as soon as recovery ends.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rom_ce_no` and `rom_oe_no` are high, `valid_o` is low and `rdata_o` is zero.
- R2: Each wait is ceil(t / CLK_NS) cycles with a minimum of one. The grade times are: fast grade address 55 ns, select 55 ns, output enable 20 ns, float 18 ns; slow grade 90, 90, 35 and 20 ns. The access length N_TOT is the largest of the three access waits.
- R3: `rom_ce_no` falls at the clock edge that accepts a request, with `rom_addr_o` updated at that same edge. The address stays stable while `rom_ce_no` is low.
- R4: `rom_oe_no` falls OE_DLY cycles after `rom_ce_no`, where OE_DLY = max(0, max(address wait, select wait) - output-enable wait). `rom_oe_no` is never low while `rom_ce_no` is high.
- R5: The memory byte is sampled at the edge exactly N_TOT cycles after `rom_ce_no` fell. At that edge `rdata_o` takes the byte, `valid_o` goes high for one cycle, and both enables rise.
- R6: After each access `rom_ce_no` stays high for at least the float wait N_DF. When a request is waiting, the next access starts exactly N_DF cycles after the previous one ended.
- R7: A request seen while busy (access or recovery) is stored with its address in one slot and served after recovery. Further requests while the slot is full are dropped.
- R8: With no request pending, `rom_ce_no` stays high and no access starts.
- R9: `rdata_o` holds the last sampled byte until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, one cycle per read |
| addr_i | input | ADDR_W | Byte address for the request |
| rdata_o | output | DATA_W | Last byte read |
| valid_o | output | 1 | One-cycle strobe: rdata_o is new |
| rom_addr_o | output | ADDR_W | Address to the memory |
| rom_ce_no | output | 1 | Memory chip select, active low |
| rom_oe_no | output | 1 | Memory output enable, active low |
| rom_data_i | input | DATA_W | Data bus from the memory |

## Verification
The bench builds three copies side by side. The first uses the fast grade at 10 ns, which gives a six-cycle access with a four-cycle delayed output enable and two recovery cycles. The second uses the slow grade at 25 ns, which gives a four-cycle access and one recovery cycle. The third uses the fast grade at 100 ns, where every wait collapses to one cycle and the output enable falls together with the chip select. Each copy talks to a memory model that returns inverted data until its own elapsed-time bookkeeping says the access times have been met, so sampling early shows up as wrong data. Back-to-back and triple requests reach the held-slot and drop paths, and at one-cycle timing they also reach the case where the slot frees in time for a third request.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RECOVER = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    TP_ADDR  = 2'd0,
    TP_CE    = 2'd1,
    TP_OE    = 2'd2,
    TP_FLOAT = 2'd3
  } rd_path_e;

  // Worst-case path times in ns per speed grade
  function automatic int unsigned path_ns(input bit fast, input rd_path_e p);
    case (p)
      TP_ADDR:  return fast ? 55 : 90;
      TP_CE:    return fast ? 55 : 90;
      TP_OE:    return fast ? 20 : 35;
      default:  return fast ? 18 : 20;
    endcase
  endfunction

  function automatic int unsigned to_cycles(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned lead_cycles(input bit fast, input int unsigned clk_ns);
    int unsigned a;
    int unsigned c;
    a = to_cycles(path_ns(fast, TP_ADDR), clk_ns);
    c = to_cycles(path_ns(fast, TP_CE), clk_ns);
    return (a > c) ? a : c;
  endfunction

  function automatic int unsigned oe_cycles(input bit fast, input int unsigned clk_ns);
    return to_cycles(path_ns(fast, TP_OE), clk_ns);
  endfunction

  function automatic int unsigned total_cycles(input bit fast, input int unsigned clk_ns);
    int unsigned l;
    int unsigned o;
    l = lead_cycles(fast, clk_ns);
    o = oe_cycles(fast, clk_ns);
    return (l > o) ? l : o;
  endfunction

  function automatic int unsigned oe_delay_cycles(input bit fast, input int unsigned clk_ns);
    int unsigned l;
    int unsigned o;
    l = lead_cycles(fast, clk_ns);
    o = oe_cycles(fast, clk_ns);
    return (l > o) ? (l - o) : 0;
  endfunction

  function automatic int unsigned float_cycles(input bit fast, input int unsigned clk_ns);
    return to_cycles(path_ns(fast, TP_FLOAT), clk_ns);
  endfunction

endpackage

// File: rtl/rom_rd_slot.sv
module rom_rd_slot #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      addr_o <= '0;
    end else if (take_i) begin
      // slot drained and refilled in the same cycle
      full_o <= capture_i;
      if (capture_i) addr_o <= addr_i;
    end else if (capture_i && !full_o) begin
      full_o <= 1'b1;
      addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/rom_rd_fsm.sv
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int unsigned N_TOT  = 6,
  parameter int unsigned OE_DLY = 4,
  parameter int unsigned N_DF   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pend_full_i,
  output logic start_o,
  output logic cap_o,
  output logic busy_o,
  output logic ce_no,
  output logic oe_no
);

  localparam int unsigned N_MAX = (N_TOT > N_DF) ? N_TOT : N_DF;
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);
  localparam logic OE_START_N = (OE_DLY == 0) ? 1'b0 : 1'b1;

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_last;
  logic             rec_last;
  logic             oe_go;

  assign acc_last = (state_q == ST_ACCESS)  && (cnt_q == CNT_W'(N_TOT - 1));
  assign rec_last = (state_q == ST_RECOVER) && (cnt_q == CNT_W'(N_DF - 1));
  assign start_o  = ((state_q == ST_IDLE) && req_i) || (rec_last && (req_i || pend_full_i));
  assign cap_o    = acc_last;
  assign busy_o   = (state_q != ST_IDLE);

  generate
    if (OE_DLY == 0) begin : g_oe_with_ce
      assign oe_go = 1'b0;
    end else begin : g_oe_late
      assign oe_go = (state_q == ST_ACCESS) && (cnt_q == CNT_W'(OE_DLY - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ce_no   <= 1'b1;
      oe_no   <= 1'b1;
    end else if (start_o) begin
      state_q <= ST_ACCESS;
      cnt_q   <= '0;
      ce_no   <= 1'b0;
      oe_no   <= OE_START_N;
    end else begin
      case (state_q)
        ST_ACCESS: begin
          if (acc_last) begin
            state_q <= ST_RECOVER;
            cnt_q   <= '0;
            ce_no   <= 1'b1;
            oe_no   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (oe_go) oe_no <= 1'b0;
          end
        end
        ST_RECOVER: begin
          if (rec_last) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter bit          FAST_GRADE = 1'b1,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  input  logic [DATA_W-1:0] rom_data_i
);

  localparam int unsigned N_TOT  = total_cycles(FAST_GRADE, CLK_NS);
  localparam int unsigned OE_DLY = oe_delay_cycles(FAST_GRADE, CLK_NS);
  localparam int unsigned N_DF   = float_cycles(FAST_GRADE, CLK_NS);

  logic              start;
  logic              cap;
  logic              busy;
  logic              pend_full;
  logic [ADDR_W-1:0] pend_addr;
  logic              slot_cap;
  logic              slot_take;

  // a request that starts an access directly never enters the slot
  assign slot_cap  = req_i && busy && !(start && !pend_full);
  assign slot_take = start && pend_full;

  rom_rd_fsm #(
    .N_TOT (N_TOT),
    .OE_DLY(OE_DLY),
    .N_DF  (N_DF)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .pend_full_i(pend_full),
    .start_o    (start),
    .cap_o      (cap),
    .busy_o     (busy),
    .ce_no      (rom_ce_no),
    .oe_no      (rom_oe_no)
  );

  rom_rd_slot #(
    .ADDR_W(ADDR_W)
  ) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(slot_cap),
    .take_i   (slot_take),
    .addr_i   (addr_i),
    .full_o   (pend_full),
    .addr_o   (pend_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_addr_o <= '0;
    end else if (start) begin
      rom_addr_o <= pend_full ? pend_addr : addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap;
      if (cap) rdata_o <= rom_data_i;
    end
  end

endmodule

// File: rtl/rom_rd_ctrl_chk.sv
module rom_rd_ctrl_chk
  import rom_rd_pkg::*;
#(
  parameter bit          FAST_GRADE = 1'b1,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned ADDR_W     = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              rom_ce_no,
  input logic              rom_oe_no
);

  localparam int unsigned N_TOT  = total_cycles(FAST_GRADE, CLK_NS);
  localparam int unsigned OE_DLY = oe_delay_cycles(FAST_GRADE, CLK_NS);
  localparam int unsigned N_DF   = float_cycles(FAST_GRADE, CLK_NS);

  logic [15:0] lo_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      if (rom_ce_no) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 16'd1;
      if (!rom_ce_no) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
    end
  end

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_ce_no && !$past(rom_ce_no)) |-> $stable(rom_addr_o));

  p_oe_inside_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_oe_no |-> !rom_ce_no);

  p_oe_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_oe_no) |-> (lo_cnt == 16'(OE_DLY)));

  p_access_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lo_cnt == 16'(N_TOT)));

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_at_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(rom_ce_no));

  p_float_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_ce_no) |-> (hi_cnt >= 16'(N_DF)));

endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
  .FAST_GRADE(FAST_GRADE),
  .CLK_NS    (CLK_NS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_o   (valid_o),
  .rom_addr_o(rom_addr_o),
  .rom_ce_no (rom_ce_no),
  .rom_oe_no (rom_oe_no)
);

// File: tb/rom_rd_ctrl_test.sv
module rom_rd_model #(
  parameter bit FAST   = 1'b1,
  parameter int CLK_NS = 10
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic [17:0] addr,
  input  logic        valid,
  input  logic [7:0]  rdata,
  output logic [7:0]  data
);
  localparam int T_LEAD = FAST ? 55 : 90;
  localparam int T_OE   = FAST ? 20 : 35;

  int ce_c = 0;
  int oe_c = 0;
  int n_valid = 0;
  int n_acc = 0;
  int lat = 0;
  int oedly = 0;
  int gap = -1;
  int lo = 0;
  int oe_hi = 0;
  int hi = 0;
  bit ce_prev = 1'b1;
  logic [7:0] first_d = 8'h00;
  logic [7:0] last_d = 8'h00;
  logic ok;

  function automatic logic [7:0] f(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'h2B, a[17:16]};
  endfunction

  always @(posedge clk) begin
    ce_c <= ce_n ? 0 : ce_c + 1;
    oe_c <= oe_n ? 0 : oe_c + 1;
  end

  assign ok = !ce_n && !oe_n && ((ce_c + 1) * CLK_NS >= T_LEAD) && ((oe_c + 1) * CLK_NS >= T_OE);
  assign data = ok ? f(addr) : ~f(addr);

  always @(negedge clk) begin
    ce_prev <= ce_n;
    if (clr) begin
      n_valid <= 0;
      n_acc <= 0;
      lat <= 0;
      oedly <= 0;
      gap <= -1;
    end else begin
      if (!ce_n) begin
        if (ce_prev) begin
          n_acc <= n_acc + 1;
          lo <= 1;
          oe_hi <= oe_n ? 1 : 0;
          if (n_acc > 0) gap <= hi;
        end else begin
          lo <= lo + 1;
          oe_hi <= oe_hi + (oe_n ? 1 : 0);
        end
      end else begin
        hi <= ce_prev ? hi + 1 : 1;
      end
      if (valid) begin
        n_valid <= n_valid + 1;
        last_d <= rdata;
        if (n_valid == 0) first_d <= rdata;
        lat <= lo;
        oedly <= oe_hi;
      end
    end
  end
endmodule

module rom_rd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [17:0] addr = '0;
  logic clr = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0]  rd_f, rd_s, rd_m;
  logic        v_f, v_s, v_m;
  logic [17:0] ra_f, ra_s, ra_m;
  logic        ce_f, ce_s, ce_m;
  logic        oe_f, oe_s, oe_m;
  logic [7:0]  md_f, md_s, md_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_rd_ctrl #(.FAST_GRADE(1'b1), .CLK_NS(10)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .rdata_o(rd_f), .valid_o(v_f), .rom_addr_o(ra_f),
    .rom_ce_no(ce_f), .rom_oe_no(oe_f), .rom_data_i(md_f));
  rom_rd_model #(.FAST(1'b1), .CLK_NS(10)) m_f (
    .clk(clk), .clr(clr), .ce_n(ce_f), .oe_n(oe_f), .addr(ra_f),
    .valid(v_f), .rdata(rd_f), .data(md_f));

  rom_rd_ctrl #(.FAST_GRADE(1'b0), .CLK_NS(25)) uut_slow (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .rdata_o(rd_s), .valid_o(v_s), .rom_addr_o(ra_s),
    .rom_ce_no(ce_s), .rom_oe_no(oe_s), .rom_data_i(md_s));
  rom_rd_model #(.FAST(1'b0), .CLK_NS(25)) m_s (
    .clk(clk), .clr(clr), .ce_n(ce_s), .oe_n(oe_s), .addr(ra_s),
    .valid(v_s), .rdata(rd_s), .data(md_s));

  rom_rd_ctrl #(.FAST_GRADE(1'b1), .CLK_NS(100)) uut_min (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .rdata_o(rd_m), .valid_o(v_m), .rom_addr_o(ra_m),
    .rom_ce_no(ce_m), .rom_oe_no(oe_m), .rom_data_i(md_m));
  rom_rd_model #(.FAST(1'b1), .CLK_NS(100)) m_m (
    .clk(clk), .clr(clr), .ce_n(ce_m), .oe_n(oe_m), .addr(ra_m),
    .valid(v_m), .rdata(rd_m), .data(md_m));

  function automatic int cyc(input int t, input int c);
    int n;
    n = (t + c - 1) / c;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int exp_tot(input bit fast, input int c);
    int l;
    int o;
    l = cyc(fast ? 55 : 90, c);
    o = cyc(fast ? 20 : 35, c);
    return (l > o) ? l : o;
  endfunction

  function automatic int exp_dly(input bit fast, input int c);
    int l;
    int o;
    l = cyc(fast ? 55 : 90, c);
    o = cyc(fast ? 20 : 35, c);
    return (l > o) ? l - o : 0;
  endfunction

  function automatic int exp_df(input bit fast, input int c);
    return cyc(fast ? 18 : 20, c);
  endfunction

  function automatic logic [7:0] fx(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'h2B, a[17:16]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    clr = 1'b1;
    @(posedge clk);
    clr = 1'b0;
  endtask

  task automatic pulse(input logic [17:0] a);
    @(negedge clk);
    req = 1'b1;
    addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 uut ce/oe/valid", {ce_f, oe_f, v_f}, 3'b110);
    chk("R1 uut_slow ce/oe/valid", {ce_s, oe_s, v_s}, 3'b110);
    chk("R1 uut_min ce/oe/valid", {ce_m, oe_m, v_m}, 3'b110);
    chk("R1 rdata zero", {rd_f, rd_s, rd_m}, 24'h0);
  endtask

  task automatic t_idle();
    clear_mon();
    repeat (12) @(negedge clk);
    chk("R8 uut no access", m_f.n_acc, 0);
    chk("R8 uut_slow no access", m_s.n_acc, 0);
    chk("R8 uut_min no access", m_m.n_acc, 0);
    chk("R8 select high", {ce_f, ce_s, ce_m}, 3'b111);
  endtask

  task automatic t_single(input logic [17:0] a);
    clear_mon();
    pulse(a);
    repeat (30) @(negedge clk);
    chk("R5 uut one strobe", m_f.n_valid, 1);
    chk("R5 uut data", m_f.last_d, fx(a));
    chk("R2 uut access length", m_f.lat, exp_tot(1'b1, 10));
    chk("R4 uut oe delay", m_f.oedly, exp_dly(1'b1, 10));
    chk("R5 uut_slow one strobe", m_s.n_valid, 1);
    chk("R5 uut_slow data", m_s.last_d, fx(a));
    chk("R2 uut_slow access length", m_s.lat, exp_tot(1'b0, 25));
    chk("R4 uut_slow oe delay", m_s.oedly, exp_dly(1'b0, 25));
    chk("R5 uut_min one strobe", m_m.n_valid, 1);
    chk("R5 uut_min data", m_m.last_d, fx(a));
    chk("R2 uut_min access length", m_m.lat, exp_tot(1'b1, 100));
    chk("R4 uut_min oe delay", m_m.oedly, exp_dly(1'b1, 100));
    chk("R3 uut address", ra_f, a);
    chk("R8 idle after read", {ce_f, oe_f, ce_s, oe_s, ce_m, oe_m}, 6'b111111);
  endtask

  task automatic t_hold(input logic [17:0] a);
    repeat (20) @(negedge clk);
    chk("R9 uut holds byte", rd_f, fx(a));
    chk("R9 uut_slow holds byte", rd_s, fx(a));
    chk("R9 uut_min holds byte", rd_m, fx(a));
  endtask

  task automatic t_b2b(input logic [17:0] a, input logic [17:0] b);
    clear_mon();
    @(negedge clk);
    req = 1'b1;
    addr = a;
    @(negedge clk);
    addr = b;
    @(negedge clk);
    req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 uut two reads", m_f.n_valid, 2);
    chk("R7 uut first", m_f.first_d, fx(a));
    chk("R7 uut held", m_f.last_d, fx(b));
    chk("R6 uut float gap", m_f.gap, exp_df(1'b1, 10));
    chk("R7 uut_slow two reads", m_s.n_valid, 2);
    chk("R7 uut_slow held", m_s.last_d, fx(b));
    chk("R6 uut_slow float gap", m_s.gap, exp_df(1'b0, 25));
    chk("R7 uut_min two reads", m_m.n_valid, 2);
    chk("R7 uut_min held", m_m.last_d, fx(b));
    chk("R6 uut_min float gap", m_m.gap, exp_df(1'b1, 100));
  endtask

  task automatic t_drop(input logic [17:0] a, input logic [17:0] b, input logic [17:0] c);
    clear_mon();
    @(negedge clk);
    req = 1'b1;
    addr = a;
    @(negedge clk);
    addr = b;
    @(negedge clk);
    addr = c;
    @(negedge clk);
    req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 uut third dropped", m_f.n_valid, 2);
    chk("R7 uut last is second", m_f.last_d, fx(b));
    chk("R7 uut_slow third dropped", m_s.n_valid, 2);
    chk("R7 uut_slow last is second", m_s.last_d, fx(b));
    // one-cycle waits free the slot before the third request
    chk("R7 uut_min third served", m_m.n_valid, 3);
    chk("R7 uut_min last is third", m_m.last_d, fx(c));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_single(18'h15A3C);
    t_hold(18'h15A3C);
    t_single(18'h3FFFF);
    t_single(18'h00000);
    t_b2b(18'h00F0F, 18'h2C3A5);
    t_drop(18'h11111, 18'h22222, 18'h33333);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule